// File: doc/BRIEF.md
# Settling Event Timer

This block is a memory-mapped event timer for a chip whose timer runs from a slow tick, for example a 32768 Hz (2^15) strobe, while the bus runs on a fast clock. A 64-bit main counter advances by one on each tick while the global run bit is set. Software reads it as two 32-bit words. Each of the comparator channels raises an interrupt a fixed number of ticks after the counter reaches its 64-bit compare value. The interrupt can be a held level or a one-cycle pulse, and the channel can send it to any one of several interrupt lines.

Writes that would cross into the tick domain are not applied at once. Each one is held in a pending slot for a fixed number of fast-clock cycles. During that time a busy bit in the status word stays set. Software polls that bit before it writes the same register again. A write that arrives while the bit is set is dropped. The counter is reported as not valid for the same period after reset and after each load. Pending interrupts are cleared by writing ones, and that write also goes through a settling slot.

Top module: `evt_timer`

## Requirements
- R1: After reset the run bit, the counter and every pending flag are 0, and no interrupt line is high. Status bit 0 (counter not valid) and bit 31 (any busy) read 1 for the first SETTLE cycles and then read 0.
- R2: A write to a channel configuration (offset 0x20+0x10*n, bit 0 interrupt enable, bit 1 level=1/pulse=0, bits 4 and up route), to a compare word (+0x4 low, +0x8 high), to the counter words (0x10 low, 0x14 high) or to the clear register (0x08) is accepted at one edge. From the next cycle its status bit reads 1 for exactly SETTLE reads. The status bits are 2+2n for channel configuration, 3+2n for channel compare, 1 for clear and 0 for counter. The value reads back as the old value until the write is applied.
- R3: A write to a register whose status bit is set is ignored.
- R4: Each tick adds 1 to the 64-bit counter while the run bit (0x00 bit 0) is 1 and the counter is valid. Without a tick the counter holds.
- R5: A write to either counter word is ignored while the run bit is 1, and its status bit stays 0.
- R6: Reading the low counter word stores the high word in a shadow. Reading 0x14 returns that shadow.
- R7: When the counter steps to the compare value, the pending flag of the channel (read at 0x08, bit n) sets on the tick that brings the counter to compare+LAT, and not before.
- R8: In level mode the line stays high until a clear is applied. Writing 1 to bit n of 0x08 clears only channel n.
- R9: In pulse mode the line is high for exactly one cycle. The pending flag still latches.
- R10: A channel drives the interrupt line whose index equals its route field.
- R11: If a clear and a new match take effect on the same edge, the pending flag ends up set.
- R12: A channel with interrupt enable 0 never sets its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per slow timer tick |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read |
| irq_line_o | output | NLINE | Interrupt lines |

## Verification
The two functions that can collide are the settling clear of a pending flag and a new match leaving the latency pipeline of the same channel. The bench schedules them to meet. It arms a compare value, counts ticks to one before the interrupt tick, and writes the clear. It then waits SETTLE-1 cycles so that the clear is applied on the edge that also carries the final tick. The flag must read back as set and the line must stay high. Separate runs with only a clear, or only a match, fix the baseline behaviour that this collision is judged against.

// File: rtl/evt_pkg.sv
// Package: register map and shared constants of the settling event timer.
// Assumes a 32-bit data bus with byte addresses and word-aligned registers.
package evt_pkg;
    localparam int          CNT_W    = 64;
    localparam logic [7:0]  ADR_RUN  = 8'h00;
    localparam logic [7:0]  ADR_STAT = 8'h04;
    localparam logic [7:0]  ADR_CLR  = 8'h08;
    localparam logic [7:0]  ADR_CNTL = 8'h10;
    localparam logic [7:0]  ADR_CNTH = 8'h14;
    localparam logic [3:0]  CH_BASE  = 4'h2;
    localparam logic [3:0]  OFF_CFG  = 4'h0;
    localparam logic [3:0]  OFF_CMPL = 4'h4;
    localparam logic [3:0]  OFF_CMPH = 4'h8;
    localparam int          ANY_BIT  = 31;
endpackage

// File: rtl/evt_settle.sv
// Settling slot: holds one accepted write for SETTLE fast cycles, then
// pulses apply_o with the held data. New writes are dropped while busy.
// Assumes SETTLE >= 1. With RST_BUSY set, the slot is busy after reset.
module evt_settle #(
    parameter int DW       = 32,
    parameter int SETTLE   = 8,
    parameter bit RST_BUSY = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          busy_o,
    output logic          apply_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] left_q;
    logic [DW-1:0] hold_q;

    // Accept a write when idle, otherwise count the settling window down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= RST_BUSY ? CW'(SETTLE) : '0;
            hold_q <= '0;
        end else if (wr_i && left_q == '0) begin
            left_q <= CW'(SETTLE);
            hold_q <= wdata_i;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy_o  = (left_q != '0);
    assign apply_o = (left_q == CW'(1));
    assign data_o  = hold_q;
endmodule

// File: rtl/evt_counter.sv
// Main counter: 64-bit tick counter, loadable one half at a time through a
// settling slot. Loads are accepted only while the run bit is 0.
// Reports busy (counter not valid) after reset and while a load settles.
module evt_counter #(
    parameter int SETTLE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    run_i,
    input  logic                    wr_i,
    input  logic                    wr_hi_i,
    input  logic [31:0]             wdata_i,
    output logic [evt_pkg::CNT_W-1:0] cnt_o,
    output logic                    busy_o,
    output logic                    step_o
);
    logic [32:0] ld_data;
    logic        ld_apply;
    logic [evt_pkg::CNT_W-1:0] cnt_q;

    evt_settle #(.DW(33), .SETTLE(SETTLE), .RST_BUSY(1'b1)) u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_i && !run_i),
        .wdata_i({wr_hi_i, wdata_i}),
        .busy_o (busy_o),
        .apply_o(ld_apply),
        .data_o (ld_data)
    );

    assign step_o = tick_i && run_i && !busy_o;

    // Apply a settled half-load, otherwise advance on an enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_apply) begin
            if (ld_data[32]) cnt_q[63:32] <= ld_data[31:0];
            else             cnt_q[31:0]  <= ld_data[31:0];
        end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_channel.sv
// Comparator channel: settled configuration and 64-bit compare value, a
// LAT-tick latency pipeline, and a pending flag that a set beats a clear on.
// Assumes step_i is high only on ticks where the counter really advances.
module evt_channel #(
    parameter int LAT    = 3,
    parameter int SETTLE = 8,
    parameter int RW     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic                      step_i,
    input  logic [evt_pkg::CNT_W-1:0] cnt_i,
    input  logic                      cfg_wr_i,
    input  logic                      cmp_wr_i,
    input  logic                      cmp_hi_i,
    input  logic [31:0]               wdata_i,
    input  logic                      clr_i,
    output logic [RW+1:0]             cfg_o,
    output logic [evt_pkg::CNT_W-1:0] cmp_o,
    output logic                      cfg_busy_o,
    output logic                      cmp_busy_o,
    output logic                      set_o,
    output logic                      pend_o,
    output logic                      irq_o
);
    logic [RW+1:0]             cfg_data, cfg_q;
    logic                      cfg_apply;
    logic [32:0]               cmp_data;
    logic                      cmp_apply;
    logic [evt_pkg::CNT_W-1:0] cmp_q;
    logic [LAT-1:0]            pipe_q;
    logic                      hit, pend_q, pulse_q;

    evt_settle #(.DW(RW+2), .SETTLE(SETTLE), .RST_BUSY(1'b0)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr_i),
        .wdata_i({wdata_i[4 +: RW], wdata_i[1:0]}),
        .busy_o (cfg_busy_o),
        .apply_o(cfg_apply),
        .data_o (cfg_data)
    );

    evt_settle #(.DW(33), .SETTLE(SETTLE), .RST_BUSY(1'b0)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cmp_wr_i),
        .wdata_i({cmp_hi_i, wdata_i}),
        .busy_o (cmp_busy_o),
        .apply_o(cmp_apply),
        .data_o (cmp_data)
    );

    // Take over the settled configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_q <= '0;
        else if (cfg_apply) cfg_q <= cfg_data;
    end

    // Take over the settled half of the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_apply) begin
            if (cmp_data[32]) cmp_q[63:32] <= cmp_data[31:0];
            else              cmp_q[31:0]  <= cmp_data[31:0];
        end
    end

    // A match counts only when the counter steps onto a settled compare value.
    assign hit = step_i && cfg_q[0] && !cfg_busy_o && !cmp_busy_o
                 && ((cnt_i + 1'b1) == cmp_q);

    generate
        if (LAT == 1) begin : g_lat1
            // Single-stage latency: the match waits for one further tick.
            always_ff @(posedge clk) begin
                if (!rst_n)      pipe_q <= '0;
                else if (tick_i) pipe_q <= hit;
            end
        end else begin : g_latn
            // Multi-stage latency: the match moves one stage per tick.
            always_ff @(posedge clk) begin
                if (!rst_n)      pipe_q <= '0;
                else if (tick_i) pipe_q <= {pipe_q[LAT-2:0], hit};
            end
        end
    endgenerate

    assign set_o = tick_i && pipe_q[LAT-1];

    // Pending flag: a new set wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (set_o) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    // One-cycle pulse for pulse-mode channels.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= set_o;
    end

    assign irq_o  = cfg_q[0] && (cfg_q[1] ? pend_q : pulse_q);
    assign pend_o = pend_q;
    assign cfg_o  = cfg_q;
    assign cmp_o  = cmp_q;
endmodule

// File: rtl/evt_timer.sv
// Top of the settling event timer: register decode, counter, NCH channels,
// settling interrupt clear, line routing and registered read data.
// Assumes NCH <= 14 so the status word fits below the any-busy bit.
module evt_timer #(
    parameter int NCH    = 2,
    parameter int NLINE  = 4,
    parameter int LAT    = 3,
    parameter int SETTLE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             bus_req_i,
    input  logic             bus_we_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic [NLINE-1:0] irq_line_o
);
    import evt_pkg::*;
    localparam int RW = (NLINE > 1) ? $clog2(NLINE) : 1;

    logic             wr, rd, run_q, cnt_busy, step, clr_busy, clr_apply;
    logic [CNT_W-1:0] cnt_val;
    logic [31:0]      shadow_q, rdata_q, rd_word, stat_w;
    logic [NCH-1:0]   clr_data, clr_v, set_v, pend_v, irq_v, cfg_busy, cmp_busy;
    logic [RW+1:0]    cfg_a [NCH];
    logic [CNT_W-1:0] cmp_a [NCH];

    assign wr = bus_req_i && bus_we_i;
    assign rd = bus_req_i && !bus_we_i;

    // Global run bit, written directly in the bus domain.
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_q <= 1'b0;
        else if (wr && bus_addr_i == ADR_RUN) run_q <= bus_wdata_i[0];
    end

    evt_counter #(.SETTLE(SETTLE)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (run_q),
        .wr_i   (wr && (bus_addr_i == ADR_CNTL || bus_addr_i == ADR_CNTH)),
        .wr_hi_i(bus_addr_i == ADR_CNTH),
        .wdata_i(bus_wdata_i),
        .cnt_o  (cnt_val),
        .busy_o (cnt_busy),
        .step_o (step)
    );

    evt_settle #(.DW(NCH), .SETTLE(SETTLE), .RST_BUSY(1'b0)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr && bus_addr_i == ADR_CLR),
        .wdata_i(bus_wdata_i[NCH-1:0]),
        .busy_o (clr_busy),
        .apply_o(clr_apply),
        .data_o (clr_data)
    );

    assign clr_v = clr_data & {NCH{clr_apply}};

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            logic ch_sel;
            assign ch_sel = wr && (bus_addr_i[7:4] == CH_BASE + 4'(n));
            evt_channel #(.LAT(LAT), .SETTLE(SETTLE), .RW(RW)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick_i),
                .step_i    (step),
                .cnt_i     (cnt_val),
                .cfg_wr_i  (ch_sel && bus_addr_i[3:0] == OFF_CFG),
                .cmp_wr_i  (ch_sel && (bus_addr_i[3:0] == OFF_CMPL ||
                                       bus_addr_i[3:0] == OFF_CMPH)),
                .cmp_hi_i  (bus_addr_i[3:0] == OFF_CMPH),
                .wdata_i   (bus_wdata_i),
                .clr_i     (clr_v[n]),
                .cfg_o     (cfg_a[n]),
                .cmp_o     (cmp_a[n]),
                .cfg_busy_o(cfg_busy[n]),
                .cmp_busy_o(cmp_busy[n]),
                .set_o     (set_v[n]),
                .pend_o    (pend_v[n]),
                .irq_o     (irq_v[n])
            );
        end
    endgenerate

    // Route each channel's interrupt onto the line its route field selects.
    always_comb begin
        irq_line_o = '0;
        for (int n = 0; n < NCH; n++) begin
            for (int l = 0; l < NLINE; l++) begin
                if (cfg_a[n][RW+1:2] == RW'(l)) irq_line_o[l] = irq_line_o[l] | irq_v[n];
            end
        end
    end

    // Assemble the status word from every settling slot.
    always_comb begin
        stat_w    = '0;
        stat_w[0] = cnt_busy;
        stat_w[1] = clr_busy;
        for (int n = 0; n < NCH; n++) begin
            stat_w[2 + 2*n] = cfg_busy[n];
            stat_w[3 + 2*n] = cmp_busy[n];
        end
        stat_w[ANY_BIT] = |stat_w[ANY_BIT-1:0];
    end

    // Select the word a read returns.
    always_comb begin
        rd_word = '0;
        case (bus_addr_i)
            ADR_RUN:  rd_word[0] = run_q;
            ADR_STAT: rd_word = stat_w;
            ADR_CLR:  rd_word[NCH-1:0] = pend_v;
            ADR_CNTL: rd_word = cnt_val[31:0];
            ADR_CNTH: rd_word = shadow_q;
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (bus_addr_i[7:4] == CH_BASE + 4'(n)) begin
                        case (bus_addr_i[3:0])
                            OFF_CFG:  rd_word = {{(26-RW){1'b0}}, cfg_a[n][RW+1:2],
                                                 2'b00, cfg_a[n][1:0]};
                            OFF_CMPL: rd_word = cmp_a[n][31:0];
                            OFF_CMPH: rd_word = cmp_a[n][63:32];
                            default:  rd_word = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    // Register read data; a low-word counter read captures the high word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            shadow_q <= '0;
        end else if (rd) begin
            rdata_q <= rd_word;
            if (bus_addr_i == ADR_CNTL) shadow_q <= cnt_val[63:32];
        end
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/evt_timer_chk.sv
// Checker for the settling event timer: counter stepping and the pending
// flag's set/clear ordering. Bound to every evt_timer instance.
module evt_timer_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic           run_q,
    input logic           cnt_busy,
    input logic [63:0]    cnt_val,
    input logic [NCH-1:0] set_v,
    input logic [NCH-1:0] pend_v,
    input logic [NCH-1:0] clr_v
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_q && !cnt_busy) |=> (cnt_val == $past(cnt_val) + 64'd1)); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_busy) |=> $stable(cnt_val)); // R4

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chk
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[n] |=> pend_v[n]); // R11
            AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_v[n] && !set_v[n]) |=> !pend_v[n]); // R8
            AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_v[n]) |-> $past(set_v[n])); // R7
        end
    endgenerate
endmodule

bind evt_timer evt_timer_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_q   (run_q),
    .cnt_busy(cnt_busy),
    .cnt_val (cnt_val),
    .set_v   (set_v),
    .pend_v  (pend_v),
    .clr_v   (clr_v)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    localparam int SET = 8;
    localparam int LAT = 3;
    localparam int NCH = 2;
    localparam int NL  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          bus_req_i = 1'b0;
    logic          bus_we_i = 1'b0;
    logic [7:0]    bus_addr_i = '0;
    logic [31:0]   bus_wdata_i = '0;
    logic [31:0]   bus_rdata_o;
    logic [NL-1:0] irq_line_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    evt_timer #(.NCH(NCH), .NLINE(NL), .LAT(LAT), .SETTLE(SET)) u_evt_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_line_o(irq_line_o)
    );

    function automatic logic [7:0] ch_adr(input int n, input logic [3:0] off);
        return {4'(2 + n), off};
    endfunction

    function automatic logic [31:0] cfg_word(input logic ie, input logic lvl, input int route);
        return (32'(route) << 4) | {30'b0, lvl, ie};
    endfunction

    function automatic logic exp_pend(input logic ie);
        return ie;  // R12: disabled channels never latch
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_req_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic settle();
        repeat (SET + 1) @(negedge clk);
    endtask

    task automatic one_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_cnt(input logic [63:0] v);
        bus_wr(8'h10, v[31:0]);  settle();
        bus_wr(8'h14, v[63:32]); settle();
    endtask

    task automatic load_cmp(input int n, input logic [63:0] v);
        bus_wr(ch_adr(n, 4'h4), v[31:0]);  settle();
        bus_wr(ch_adr(n, 4'h8), v[63:32]); settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        logic [31:0] r;
        logic [63:0] base, tgt;
        int d;
        logic ie;
        void'($urandom(32'h5EED_0123));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(8'h04, r);
        check("R1 counter not valid", r[0], 1'b1);
        check("R1 any busy", r[31], 1'b1);
        bus_rd(8'h10, r); check("R1 counter low", r, 0);
        bus_rd(8'h08, r); check("R1 pending", r, 0);
        bus_rd(8'h00, r); check("R1 run bit", r, 0);
        check("R1 lines", irq_line_o, 0);
        settle();
        bus_rd(8'h04, r); check("R1 status clear", r, 0);

        // R2 settle window, R3 write while busy is dropped
        bus_wr(ch_adr(0, 4'h0), cfg_word(1'b1, 1'b1, 0));
        bus_wr(ch_adr(0, 4'h0), 32'h0);
        bus_rd(8'h04, r); check("R2 cfg busy early", r[2], 1'b1);
        repeat (SET - 3) @(negedge clk);
        bus_rd(8'h04, r); check("R2 cfg busy last", r[2], 1'b1);
        bus_rd(8'h04, r); check("R2 cfg busy ended", r[2], 1'b0);
        bus_rd(ch_adr(0, 4'h0), r); check("R3 busy write ignored", r, cfg_word(1'b1, 1'b1, 0));
        bus_wr(ch_adr(1, 4'h0), cfg_word(1'b1, 1'b1, 3));
        bus_rd(ch_adr(1, 4'h0), r); check("R2 old value while settling", r, 0);
        settle();
        bus_rd(ch_adr(1, 4'h0), r); check("R2 new value", r, cfg_word(1'b1, 1'b1, 3));

        // R4 R5 R6 counter load, step and shadow
        load_cnt({32'h5, 32'hFFFF_FFFF});
        bus_rd(8'h10, r); check("R5 load low", r, 32'hFFFF_FFFF);
        bus_rd(8'h14, r); check("R6 shadow after low read", r, 32'h5);
        bus_wr(8'h00, 32'h1);
        bus_wr(8'h10, 32'h0);
        bus_rd(8'h04, r); check("R5 no busy when running", r[0], 1'b0);
        settle();
        bus_rd(8'h10, r); check("R5 load ignored when running", r, 32'hFFFF_FFFF);
        one_tick();
        bus_rd(8'h14, r); check("R6 shadow holds old high", r, 32'h5);
        bus_rd(8'h10, r); check("R4 low after carry", r, 0);
        bus_rd(8'h14, r); check("R4 high after carry", r, 32'h6);
        repeat (5) @(negedge clk);
        bus_rd(8'h10, r); check("R4 holds without tick", r, 0);

        // R7 R8 R12 random compare distances, enables and start values
        for (int it = 0; it < 12; it++) begin
            bus_wr(8'h00, 32'h0);
            base = {$urandom(), $urandom()};
            d = 1 + ($urandom() % 6);
            tgt = base + 64'(d);
            ie = 1'($urandom() % 2);
            load_cnt(base);
            load_cmp(0, tgt);
            bus_wr(ch_adr(0, 4'h0), cfg_word(ie, 1'b1, 0)); settle();
            bus_wr(8'h00, 32'h1);
            for (int t = 0; t < d + LAT - 1; t++) one_tick();
            bus_rd(8'h08, r); check("R7 not before latency", r[0], 1'b0);
            one_tick();
            bus_rd(8'h08, r); check("R7 R12 pending at latency", r[0], exp_pend(ie));
            one_tick(); one_tick();
            check("R8 level held", irq_line_o[0], exp_pend(ie));
            bus_wr(8'h08, 32'h1); settle();
            bus_rd(8'h08, r); check("R8 cleared", r[0], 1'b0);
        end

        // R9 pulse mode, R10 routing, R8 per-channel clear
        bus_wr(8'h00, 32'h0);
        load_cnt(64'd100);
        load_cmp(0, 64'd103);
        load_cmp(1, 64'd103);
        bus_wr(ch_adr(0, 4'h0), cfg_word(1'b1, 1'b0, 0)); settle();
        bus_wr(8'h00, 32'h1);
        for (int t = 0; t < 5; t++) one_tick();
        check("R7 lines quiet before", irq_line_o, 0);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check("R9 R10 pulse and routed level", irq_line_o, 4'b1001);
        @(negedge clk);
        check("R9 pulse one cycle", irq_line_o, 4'b1000);
        bus_rd(8'h08, r); check("R9 pending latched", r, 32'h3);
        bus_wr(8'h08, 32'h2); settle();
        bus_rd(8'h08, r); check("R8 clears only channel 1", r, 32'h1);
        check("R10 line 3 released", irq_line_o, 0);
        bus_wr(8'h08, 32'h1); settle();

        // R11 clear and new match applied on the same edge
        bus_wr(ch_adr(0, 4'h0), cfg_word(1'b1, 1'b1, 0)); settle();
        load_cmp(0, 64'd108);
        for (int t = 0; t < 4; t++) one_tick();
        bus_rd(8'h08, r); check("R11 pending still clear", r[0], 1'b0);
        bus_wr(8'h08, 32'h1);
        bus_wr(8'h08, 32'h1);  // R3: dropped while the clear settles
        repeat (SET - 2) @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        @(negedge clk);
        bus_rd(8'h08, r); check("R11 set wins over clear", r[0], 1'b1);
        check("R11 line stays high", irq_line_o[0], 1'b1);
        repeat (SET) @(negedge clk);
        bus_rd(8'h08, r); check("R3 second clear was dropped", r[0], 1'b1);
        bus_wr(8'h08, 32'h1); settle();
        bus_rd(8'h08, r); check("R8 clear alone works", r[0], 1'b0);

        report();
    end
endmodule